// File: doc/BRIEF.md
# Set-Associative Address Translation Lookup

This block translates a 32-bit virtual address into a physical address through a four-way, sixteen-row translation table with 8 KiB pages. A request carries the address, the current 8-bit process tag, the kind of access (read, write or instruction fetch), a user-mode flag and a debug flag. Only one row is searched: the one picked by the low four bits of the page number. All four ways of that row are compared in parallel.

On a hit, a set of protection checks is applied in a fixed order. Four enable bits turn the individual checks on. The block then returns either the physical address with read, write and execute grants, or a fault vector number. A fault that is not a debug probe records what went wrong in a cause register. It also records in a refill-select register the row and the way that software should overwrite. For a miss, that way comes from a 16-bit LFSR. Table entries are loaded through a plain one-cycle write port that takes the entry fields directly.

Top module: `tlb_lookup`

## Requirements
- R1: A way hits when its stored page number equals reqAddr[31:13] and either its global flag (flag bit 4) is set or its stored process tag equals reqPid. The searched row is reqAddr[16:13].
- R2: When several ways of the row hit, the way with the lowest number supplies the result.
- R3: A lookup that passes returns rspPhys = {stored frame number, reqAddr[12:0]}, rspRead = 1, rspWrite = the entry's write flag (bit 1), and rspExec = 1 only for a fetch (reqKind 2) where the exec check (checkEn[1]) or the entry's exec flag (bit 0) is set. rspVector is 0.
- R4: After a hit, the checks are tried in this order, and the first that applies sets the offset. Offset 2: the entry's kernel flag (bit 2) is set, reqUser is 1 and checkEn[2] is set. Offset 3: a write (reqKind 1) to an entry whose write flag is clear, with checkEn[3] set. Offset 3: a fetch to an entry whose exec flag is clear, with checkEn[1] set. Offset 1: an entry whose valid flag (bit 3) is clear, with checkEn[0] set.
- R5: The fault vector is the base plus the offset, where a miss has offset 0. The base is 4 for fetches and 8 for every other kind.
- R6: A faulting lookup returns rspFault = 1, rspPhys = 0, and all three grants 0.
- R7: A non-debug fault loads selReg with the row in [3:0] and a way in [5:4]. The way is the LFSR's bits [1:0] for a miss, and the hitting way for a protection fault.
- R8: A non-debug fault loads causeReg with the page number in [31:13], the access kind in [9:8] (read 0, write 1, fetch 2; kind 3 is recorded as read) and reqPid in [7:0]. Bits [12:10] are zero.
- R9: The LFSR resets to 0xCCCC. It steps only on a non-debug fault. Each step shifts it right by one and puts into bit 15 the parity of the old value ANDed with 0x8805. The refill way is taken from the value before the step.
- R10: A lookup with reqDebug = 1 leaves causeReg, selReg and the LFSR unchanged.
- R11: A request accepted at a clock edge shows its result, with rspValid = 1, after that same edge. rspValid is 0 after an edge with no request. A lookup sees the table as it was before a write in the same cycle.
- R12: After reset, rspValid, causeReg and selReg are zero and every table entry is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Load one table entry this cycle |
| wrWay | input | 2 | Way of the entry to load |
| wrIdx | input | 4 | Row of the entry to load |
| wrVpn | input | 19 | Page number to store |
| wrPid | input | 8 | Process tag to store |
| wrPfn | input | 19 | Frame number to store |
| wrFlags | input | 5 | Flags: 4 global, 3 valid, 2 kernel, 1 write, 0 exec |
| checkEn | input | 4 | Check enables: 3 write, 2 kernel, 1 exec, 0 valid |
| reqValid | input | 1 | Lookup request this cycle |
| reqAddr | input | 32 | Virtual address |
| reqPid | input | 8 | Current process tag |
| reqKind | input | 2 | 0 read, 1 write, 2 fetch, 3 treated as read |
| reqUser | input | 1 | Access made from user mode |
| reqDebug | input | 1 | Probe without side effects |
| rspValid | output | 1 | Result registered this cycle |
| rspFault | output | 1 | Lookup faulted |
| rspVector | output | 4 | Fault vector number, 0 on success |
| rspPhys | output | 32 | Physical address, 0 on fault |
| rspRead | output | 1 | Read granted |
| rspWrite | output | 1 | Write granted |
| rspExec | output | 1 | Execute granted |
| causeReg | output | 32 | Last fault cause |
| selReg | output | 6 | Suggested refill slot |

## Verification
The assertions assume that reset is applied before the first request. They also assume that every input is stable around the rising clock edge, so that the request and write fields seen by the lookup, the cause and select logic and the LFSR belong to the same cycle. The stimulus changes inputs one time unit after each rising edge. It uses a small pool of page numbers so that hits, multi-way hits, misses and every protection path all occur. It includes debug probes, fetches and same-cycle writes to the row being looked up.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Entry flag positions (software-visible through the write port)
  localparam int FLAG_EXEC   = 0;
  localparam int FLAG_WRITE  = 1;
  localparam int FLAG_KERNEL = 2;
  localparam int FLAG_VALID  = 3;
  localparam int FLAG_GLOBAL = 4;
  localparam int FLAG_W      = 5;

  // Check-enable positions
  localparam int CHK_VALID  = 0;
  localparam int CHK_EXEC   = 1;
  localparam int CHK_KERNEL = 2;
  localparam int CHK_WRITE  = 3;
  localparam int CHK_W      = 4;

  // Replacement LFSR
  localparam int              LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hCCCC;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h8805;

  // Cause register layout: kind field position
  localparam int KIND_LSB = 8;

  localparam int VEC_W = 4;
  localparam logic [VEC_W-1:0] VEC_BASE_FETCH = 4'd4;
  localparam logic [VEC_W-1:0] VEC_BASE_DATA  = 4'd8;

  localparam logic [1:0] OFF_MISS    = 2'd0;
  localparam logic [1:0] OFF_INVALID = 2'd1;
  localparam logic [1:0] OFF_KERNEL  = 2'd2;
  localparam logic [1:0] OFF_PERM    = 2'd3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_ALT   = 2'd3
  } accKind_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // register a lookup result
    logic logFault;  // load cause and select registers
    logic stepLfsr;  // advance replacement LFSR
  } ctrlStrobe_t;

endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqDebug,
  input  logic             lookupFault,
  output ctrlStrobe_t      strobe,
  output logic [WAY_W-1:0] refillWay
);

  logic [LFSR_W-1:0] lfsrQ;
  logic              feedBit;

  assign strobe.capture  = reqValid;
  assign strobe.logFault = reqValid && lookupFault && !reqDebug;
  assign strobe.stepLfsr = reqValid && lookupFault && !reqDebug;

  assign feedBit = ^(lfsrQ & LFSR_TAPS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ <= LFSR_SEED;
    end else if (strobe.stepLfsr) begin
      lfsrQ <= {feedBit, lfsrQ[LFSR_W-1:1]};
    end
  end

  // Way chosen before the step takes effect
  assign refillWay = lfsrQ[WAY_W-1:0];

  // R9: LFSR only moves on a logged fault
  p_lfsr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.stepLfsr |=> $stable(lfsrQ));

  // R9: the generator never falls into the all-zero state
  p_lfsr_live_r9: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int ROWS      = 16,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int PID_W     = 8,
  localparam int IDX_W    = $clog2(ROWS),
  localparam int WAY_W    = $clog2(WAYS),
  localparam int VPN_W    = ADDR_W - PAGE_BITS,
  localparam int SEL_W    = IDX_W + WAY_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [WAY_W-1:0]     wrWay,
  input  logic [IDX_W-1:0]     wrIdx,
  input  logic [VPN_W-1:0]     wrVpn,
  input  logic [PID_W-1:0]     wrPid,
  input  logic [VPN_W-1:0]     wrPfn,
  input  logic [FLAG_W-1:0]    wrFlags,
  input  logic [CHK_W-1:0]     checkEn,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [PID_W-1:0]     reqPid,
  input  logic [1:0]           reqKind,
  input  logic                 reqUser,
  input  logic [WAY_W-1:0]     refillWay,
  input  ctrlStrobe_t          strobe,
  output logic                 lookupFault,
  output logic                 rspValid,
  output logic                 rspFault,
  output logic [VEC_W-1:0]     rspVector,
  output logic [ADDR_W-1:0]    rspPhys,
  output logic                 rspRead,
  output logic                 rspWrite,
  output logic                 rspExec,
  output logic [ADDR_W-1:0]    causeReg,
  output logic [SEL_W-1:0]     selReg
);

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PID_W-1:0]  pid;
    logic [VPN_W-1:0]  pfn;
    logic [FLAG_W-1:0] flags;
  } entry_t;

  entry_t entryMem [WAYS][ROWS];

  // ---------------- entry storage ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) begin
        for (int r = 0; r < ROWS; r++) begin
          entryMem[w][r] <= '0;
        end
      end
    end else if (wrEn) begin
      entryMem[wrWay][wrIdx] <= '{vpn: wrVpn, pid: wrPid, pfn: wrPfn, flags: wrFlags};
    end
  end

  // ---------------- tag compare ----------------
  logic [VPN_W-1:0] reqVpn;
  logic [IDX_W-1:0] reqIdx;
  logic [WAYS-1:0]  wayHit;

  assign reqVpn = reqAddr[ADDR_W-1:PAGE_BITS];
  assign reqIdx = reqVpn[IDX_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    entry_t rowEntry;
    assign rowEntry  = entryMem[w][reqIdx];
    assign wayHit[w] = (rowEntry.vpn == reqVpn) &&
                       (rowEntry.flags[FLAG_GLOBAL] || (rowEntry.pid == reqPid));
  end

  // Lowest-numbered hitting way wins
  logic             anyHit;
  logic [WAY_W-1:0] hitWay;

  always_comb begin
    anyHit = 1'b0;
    hitWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (wayHit[w]) begin
        anyHit = 1'b1;
        hitWay = WAY_W'(w);
      end
    end
  end

  entry_t hitEntry;
  assign hitEntry = entryMem[hitWay][reqIdx];

  // ---------------- protection checks ----------------
  accKind_t kind;
  logic     isWrite, isFetch;
  logic     kernelTrip, writeTrip, execTrip, validTrip;
  logic [1:0] vecOff;
  logic     faultNow;

  assign kind    = accKind_t'(reqKind);
  assign isWrite = (kind == ACC_WRITE);
  assign isFetch = (kind == ACC_FETCH);

  assign kernelTrip = checkEn[CHK_KERNEL] && hitEntry.flags[FLAG_KERNEL] && reqUser;
  assign writeTrip  = isWrite && checkEn[CHK_WRITE] && !hitEntry.flags[FLAG_WRITE];
  assign execTrip   = isFetch && checkEn[CHK_EXEC]  && !hitEntry.flags[FLAG_EXEC];
  assign validTrip  = checkEn[CHK_VALID] && !hitEntry.flags[FLAG_VALID];

  always_comb begin
    faultNow = 1'b1;
    vecOff   = OFF_MISS;
    if (!anyHit) begin
      vecOff = OFF_MISS;
    end else if (kernelTrip) begin
      vecOff = OFF_KERNEL;
    end else if (writeTrip || execTrip) begin
      vecOff = OFF_PERM;
    end else if (validTrip) begin
      vecOff = OFF_INVALID;
    end else begin
      faultNow = 1'b0;
    end
  end

  assign lookupFault = faultNow;

  logic [VEC_W-1:0]  vecNext;
  logic [ADDR_W-1:0] physNext;
  logic              execGrant;
  accKind_t          causeKind;
  logic [ADDR_W-1:0] causeNext;
  logic [SEL_W-1:0]  selNext;

  assign vecNext   = (isFetch ? VEC_BASE_FETCH : VEC_BASE_DATA) + {2'b00, vecOff};
  assign physNext  = {hitEntry.pfn, reqAddr[PAGE_BITS-1:0]};
  assign execGrant = isFetch && (checkEn[CHK_EXEC] || hitEntry.flags[FLAG_EXEC]);
  assign causeKind = (kind == ACC_ALT) ? ACC_READ : kind;

  always_comb begin
    causeNext = '0;
    causeNext[ADDR_W-1:PAGE_BITS]   = reqVpn;
    causeNext[KIND_LSB+1:KIND_LSB]  = causeKind;
    causeNext[PID_W-1:0]            = reqPid;
  end

  assign selNext = {(anyHit ? hitWay : refillWay), reqIdx};

  // ---------------- result registers ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspFault  <= 1'b0;
      rspVector <= '0;
      rspPhys   <= '0;
      rspRead   <= 1'b0;
      rspWrite  <= 1'b0;
      rspExec   <= 1'b0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) begin
        rspFault  <= faultNow;
        rspVector <= faultNow ? vecNext : '0;
        rspPhys   <= faultNow ? '0 : physNext;
        rspRead   <= !faultNow;
        rspWrite  <= !faultNow && hitEntry.flags[FLAG_WRITE];
        rspExec   <= !faultNow && execGrant;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      causeReg <= '0;
      selReg   <= '0;
    end else if (strobe.logFault) begin
      causeReg <= causeNext;
      selReg   <= selNext;
    end
  end

  // R6: a fault grants nothing and returns no address
  p_fault_clears_perms_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault) |-> (!rspRead && !rspWrite && !rspExec && (rspPhys == '0)));

  // R3: a successful lookup always grants read and reports no vector
  p_success_reads_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> (rspRead && (rspVector == '0)));

  // R7: logged fault records the searched row
  p_sel_index_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.logFault |=> (selReg[IDX_W-1:0] == $past(reqIdx)));

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int ROWS      = 16,
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 13,
  parameter int PID_W     = 8,
  localparam int IDX_W    = $clog2(ROWS),
  localparam int WAY_W    = $clog2(WAYS),
  localparam int VPN_W    = ADDR_W - PAGE_BITS,
  localparam int SEL_W    = IDX_W + WAY_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [WAY_W-1:0]  wrWay,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [VPN_W-1:0]  wrVpn,
  input  logic [PID_W-1:0]  wrPid,
  input  logic [VPN_W-1:0]  wrPfn,
  input  logic [4:0]        wrFlags,
  input  logic [3:0]        checkEn,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [PID_W-1:0]  reqPid,
  input  logic [1:0]        reqKind,
  input  logic              reqUser,
  input  logic              reqDebug,
  output logic              rspValid,
  output logic              rspFault,
  output logic [3:0]        rspVector,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec,
  output logic [ADDR_W-1:0] causeReg,
  output logic [SEL_W-1:0]  selReg
);

  ctrlStrobe_t      strobe;
  logic             lookupFault;
  logic [WAY_W-1:0] refillWay;

  tlb_ctrl #(.WAY_W(WAY_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqDebug    (reqDebug),
    .lookupFault (lookupFault),
    .strobe      (strobe),
    .refillWay   (refillWay)
  );

  tlb_datapath #(
    .WAYS      (WAYS),
    .ROWS      (ROWS),
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .PID_W     (PID_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrWay       (wrWay),
    .wrIdx       (wrIdx),
    .wrVpn       (wrVpn),
    .wrPid       (wrPid),
    .wrPfn       (wrPfn),
    .wrFlags     (wrFlags),
    .checkEn     (checkEn),
    .reqAddr     (reqAddr),
    .reqPid      (reqPid),
    .reqKind     (reqKind),
    .reqUser     (reqUser),
    .refillWay   (refillWay),
    .strobe      (strobe),
    .lookupFault (lookupFault),
    .rspValid    (rspValid),
    .rspFault    (rspFault),
    .rspVector   (rspVector),
    .rspPhys     (rspPhys),
    .rspRead     (rspRead),
    .rspWrite    (rspWrite),
    .rspExec     (rspExec),
    .causeReg    (causeReg),
    .selReg      (selReg)
  );

  // R11: every request produces a result on the next cycle
  p_resp_follows_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R11: no request, no result
  p_idle_no_resp_r11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R10: debug probes leave the fault record alone
  p_debug_keeps_state_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqDebug) |=> ($stable(causeReg) && $stable(selReg)));

endmodule

// File: tb/tlb_lookup_test.sv
module tlb_lookup_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrWay = '0;
  logic [3:0]  wrIdx = '0;
  logic [18:0] wrVpn = '0;
  logic [7:0]  wrPid = '0;
  logic [18:0] wrPfn = '0;
  logic [4:0]  wrFlags = '0;
  logic [3:0]  checkEn = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [7:0]  reqPid = '0;
  logic [1:0]  reqKind = '0;
  logic        reqUser = 1'b0;
  logic        reqDebug = 1'b0;
  logic        rspValid, rspFault, rspRead, rspWrite, rspExec;
  logic [3:0]  rspVector;
  logic [31:0] rspPhys, causeReg;
  logic [5:0]  selReg;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_lookup uut (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrWay(wrWay), .wrIdx(wrIdx), .wrVpn(wrVpn), .wrPid(wrPid),
    .wrPfn(wrPfn), .wrFlags(wrFlags), .checkEn(checkEn),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqPid(reqPid), .reqKind(reqKind),
    .reqUser(reqUser), .reqDebug(reqDebug),
    .rspValid(rspValid), .rspFault(rspFault), .rspVector(rspVector), .rspPhys(rspPhys),
    .rspRead(rspRead), .rspWrite(rspWrite), .rspExec(rspExec),
    .causeReg(causeReg), .selReg(selReg)
  );

  int compared = 0;
  int mismatched = 0;
  bit started = 0;
  bit finished = 0;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [18:0] mVpn [4][16];
  logic [7:0]  mPid [4][16];
  logic [18:0] mPfn [4][16];
  logic [4:0]  mFlg [4][16];
  logic [15:0] mLfsr;
  logic        eValid, eFault, eR, eW, eX;
  logic [3:0]  eVec;
  logic [31:0] ePhys, eCause;
  logic [5:0]  eSel;

  task automatic modelLookup();
    int way;
    int off;
    logic [18:0] page;
    logic [3:0]  idx;
    logic [4:0]  fl;
    logic        isEx;
    logic [1:0]  k;
    page = reqAddr[31:13];
    idx  = page[3:0];
    way  = -1;
    for (int w = 0; w < 4; w++) begin
      if (way < 0 && mVpn[w][idx] == page && (mFlg[w][idx][4] || mPid[w][idx] == reqPid))
        way = w;
    end
    isEx = (reqKind == 2'd2);
    off  = -1;
    fl   = '0;
    if (way < 0) off = 0;
    else begin
      fl = mFlg[way][idx];
      if (checkEn[2] && fl[2] && reqUser) off = 2;
      else if (reqKind == 2'd1 && checkEn[3] && !fl[1]) off = 3;
      else if (isEx && checkEn[1] && !fl[0]) off = 3;
      else if (checkEn[0] && !fl[3]) off = 1;
    end
    if (off < 0) begin
      eFault = 0; eVec = 0;
      ePhys = {mPfn[way][idx], reqAddr[12:0]};
      eR = 1; eW = fl[1]; eX = isEx && (checkEn[1] || fl[0]);
    end else begin
      eFault = 1; eVec = 4'((isEx ? 4 : 8) + off);
      ePhys = 0; eR = 0; eW = 0; eX = 0;
      if (!reqDebug) begin
        k = (reqKind == 2'd3) ? 2'd0 : reqKind;
        eSel = {((way < 0) ? mLfsr[1:0] : 2'(way)), idx};
        eCause = {page, 3'b000, k, reqPid};
        mLfsr = {1'($countones(mLfsr & 16'h8805) % 2), mLfsr[15:1]};
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < 4; w++)
        for (int r = 0; r < 16; r++) begin
          mVpn[w][r] = '0; mPid[w][r] = '0; mPfn[w][r] = '0; mFlg[w][r] = '0;
        end
      mLfsr = 16'hCCCC;
      eValid = 0; eFault = 0; eR = 0; eW = 0; eX = 0;
      eVec = 0; ePhys = 0; eCause = 0; eSel = 0;
    end else begin
      eValid = reqValid;
      if (reqValid) modelLookup();  // sees the table before this cycle's write (R11)
      if (wrEn) begin
        mVpn[wrWay][wrIdx] = wrVpn; mPid[wrWay][wrIdx] = wrPid;
        mPfn[wrWay][wrIdx] = wrPfn; mFlg[wrWay][wrIdx] = wrFlags;
      end
    end
    started = 1;
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R11 rspValid", 32'(rspValid), 32'(eValid));
      chk("R6 rspFault", 32'(rspFault), 32'(eFault));
      chk("R4 R5 rspVector", 32'(rspVector), 32'(eVec));
      chk("R3 rspPhys", rspPhys, ePhys);
      chk("R3 rspRead", 32'(rspRead), 32'(eR));
      chk("R3 rspWrite", 32'(rspWrite), 32'(eW));
      chk("R3 rspExec", 32'(rspExec), 32'(eX));
      chk("R8 causeReg", causeReg, eCause);
      chk("R7 selReg", 32'(selReg), 32'(eSel));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic writeEntry(input logic [1:0] w, input logic [3:0] i, input logic [18:0] v,
                            input logic [7:0] p, input logic [18:0] f, input logic [4:0] fl);
    wrEn = 1; wrWay = w; wrIdx = i; wrVpn = v; wrPid = p; wrPfn = f; wrFlags = fl;
    @(posedge clk); #1;
    wrEn = 0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic [7:0] p, input logic [1:0] k,
                        input logic u, input logic d);
    reqValid = 1; reqAddr = a; reqPid = p; reqKind = k; reqUser = u; reqDebug = d;
    @(posedge clk); #1;
    reqValid = 0; reqDebug = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R12: reset state
    chk("R12 rspValid after reset", 32'(rspValid), 0);
    chk("R12 causeReg after reset", causeReg, 0);
    chk("R12 selReg after reset", 32'(selReg), 0);

    checkEn = 4'b0000;
    // First miss: way from the seed (0xCCCC -> 0)
    lookup(32'h00EE_E000, 8'h09, 2'd0, 0, 0);
    chk("R9 first refill slot", 32'(selReg), 32'h07);
    chk("R5 miss data vector", 32'(rspVector), 8);
    chk("R8 cause of first miss", causeReg, 32'h00EE_E009);
    chk("R6 miss returns no address", rspPhys, 0);
    // Debug probe of a missing fetch
    lookup(32'h0060_0000, 8'h01, 2'd2, 0, 1);
    chk("R5 fetch miss vector", 32'(rspVector), 4);
    chk("R10 debug keeps select", 32'(selReg), 32'h07);
    chk("R10 debug keeps cause", causeReg, 32'h00EE_E009);
    // Second real miss: LFSR stepped once to 0xE666 -> way 2
    lookup(32'h0060_2000, 8'h02, 2'd1, 0, 0);
    chk("R9 second refill slot", 32'(selReg), 32'h21);
    chk("R8 cause of write miss", causeReg, 32'h0060_2102);

    // R2: two ways of row 5 hit; way 1 must win
    writeEntry(2'd2, 4'd5, 19'h000A5, 8'h03, 19'h00123, 5'h0A);
    writeEntry(2'd1, 4'd5, 19'h000A5, 8'h07, 19'h00456, 5'h18);
    lookup(32'h0014_B234, 8'h03, 2'd0, 0, 0);
    chk("R2 lowest way phys", rspPhys, 32'h008A_D234);
    chk("R2 lowest way write grant", 32'(rspWrite), 0);

    // R1: tag match needed when not global
    writeEntry(2'd3, 4'd6, 19'h000B6, 8'h04, 19'h000AB, 5'h0F);
    lookup(32'h0016_C000, 8'h05, 2'd0, 0, 0);
    chk("R1 foreign tag misses", 32'(rspFault), 1);
    lookup(32'h0016_C010, 8'h04, 2'd0, 0, 0);
    chk("R1 own tag hits", rspPhys, 32'h0015_6010);

    // R3: execute grant
    lookup(32'h0016_C000, 8'h04, 2'd2, 0, 0);
    chk("R3 exec grant from entry", 32'(rspExec), 1);
    lookup(32'h0014_A000, 8'h00, 2'd2, 0, 0);
    chk("R3 exec denied without flag", 32'(rspExec), 0);

    // R4: priority of protection checks
    checkEn = 4'b1111;
    lookup(32'h0016_C000, 8'h04, 2'd1, 1, 0);
    chk("R4 kernel before write", 32'(rspVector), 10);
    chk("R7 protection fault keeps hit way", 32'(selReg), 32'h36);
    lookup(32'h0016_C000, 8'h04, 2'd1, 0, 0);
    chk("R4 kernel entry from supervisor", 32'(rspFault), 0);
    lookup(32'h0014_A000, 8'h00, 2'd1, 0, 0);
    chk("R4 write protection", 32'(rspVector), 11);
    lookup(32'h0014_A000, 8'h00, 2'd2, 0, 0);
    chk("R4 exec protection", 32'(rspVector), 7);
    writeEntry(2'd0, 4'd9, 19'h000A9, 8'h00, 19'h00011, 5'h03);
    lookup(32'h0015_2000, 8'h00, 2'd0, 0, 0);
    chk("R4 invalid entry", 32'(rspVector), 9);
    checkEn = 4'b1110;
    lookup(32'h0015_2000, 8'h00, 2'd0, 0, 0);
    chk("R4 invalid ignored without check", 32'(rspFault), 0);

    // R11: lookup in the same cycle as a write sees the old entry
    checkEn = 4'b0000;
    wrEn = 1; wrWay = 2'd0; wrIdx = 4'd12; wrVpn = 19'h000AC; wrPid = 8'h00;
    wrPfn = 19'h00777; wrFlags = 5'h08;
    reqValid = 1; reqAddr = 32'h0015_8000; reqPid = 8'h00; reqKind = 2'd0;
    reqUser = 0; reqDebug = 0;
    @(posedge clk); #1;
    wrEn = 0; reqValid = 0;
    chk("R11 same-cycle write not seen", 32'(rspFault), 1);
    lookup(32'h0015_8000, 8'h00, 2'd0, 0, 0);
    chk("R11 write seen next cycle", rspPhys, 32'h00EE_E000);
    @(posedge clk); #1;
    chk("R11 idle clears valid", 32'(rspValid), 0);

    // Mixed traffic over a small page pool
    for (int i = 0; i < 3000; i++) begin
      logic [18:0] pg;
      wrEn    = ($urandom % 3) == 0;
      wrWay   = 2'($urandom);
      wrIdx   = 4'($urandom);
      wrVpn   = 19'((($urandom % 4) << 4) | wrIdx);
      wrPid   = 8'($urandom % 4);
      wrPfn   = 19'($urandom);
      wrFlags = 5'($urandom);
      pg      = 19'((($urandom % 4) << 4) | ($urandom % 16));
      reqValid = ($urandom % 4) != 0;
      reqAddr  = {pg, 13'($urandom)};
      reqPid   = 8'($urandom % 4);
      reqKind  = 2'($urandom);
      reqUser  = 1'($urandom);
      reqDebug = ($urandom % 8) == 0;
      checkEn  = 4'($urandom);
      @(posedge clk); #1;
    end
    wrEn = 0; reqValid = 0; reqDebug = 0;
    @(posedge clk); #1;
    @(negedge clk); #1;
    summary();
  end

endmodule